// File: doc/BRIEF.md
# Bit-Serial NAND Load-Load-Store Processor

This block is a minimal stored-program processor built around a single two-input NAND gate. It drives an external memory that is addressed per bit and moves one bit per access. The memory port has an address output, a read-data bit input, a write-data bit output and a write-enable output. Reads are synchronous: the bit at the address presented in one cycle arrives on `mem_rdata` in the next cycle.

An instruction has no opcode. It is a bare bit address, `ADDR_W` bits wide. The program counter fetches it one bit at a time, most significant bit first, into an instruction register. The instruction register then supplies the memory address while the instruction executes. Instructions always run in the same rotation: the first loads operand A, the second loads operand B, and the third stores NOT(A AND B). The rotation then starts again. The program counter only counts upward and wraps to zero, so a program loops forever.

There are two ways to stop the machine. A store of 0 to the stop address `STOP_ADDR` halts it. So does the `halt_req` input, which is taken at the next instruction boundary. Only a synchronous reset leaves the halted state.

The controller has six states. Their transitions are:

| State | Condition | Next state |
|---|---|---|
| ST_FETCH_REQ | `halt_req` high at an instruction boundary | ST_HALTED |
| ST_FETCH_REQ | otherwise | ST_FETCH_CAP |
| ST_FETCH_CAP | bits remain to fetch | ST_FETCH_REQ |
| ST_FETCH_CAP | last bit, load phase | ST_LOAD_REQ |
| ST_FETCH_CAP | last bit, store phase | ST_STORE |
| ST_LOAD_REQ | always | ST_LOAD_CAP |
| ST_LOAD_CAP | always; phase advances A to B, or B to store | ST_FETCH_REQ |
| ST_STORE | stop condition | ST_HALTED |
| ST_STORE | otherwise; phase returns to load A | ST_FETCH_REQ |
| ST_HALTED | always | ST_HALTED |

Top module: `serial_nand_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, instruction register, fill counter, phase and halted flag. While reset is held and after it, `halted`=0, `mem_we`=0 and `mem_addr`=0.
- R2: Each instruction bit takes two cycles. In the first cycle `mem_addr` equals the PC. In the next cycle the returned bit is captured and the PC increments. `mem_addr` therefore reads 0,0,1,1,2,2,… over the first 2*ADDR_W cycles after reset.
- R3: The first fetched bit becomes the most significant bit of the instruction. When all ADDR_W bits are in, the assembled word drives `mem_addr` for execution. With ADDR_W=8, the first load issues its address in cycle 2*ADDR_W after reset.
- R4: Instructions rotate through load A, load B and store, then repeat. A load drives the instruction address for one cycle and captures the returned bit in the next cycle. A load instruction takes 2*ADDR_W+2 cycles.
- R5: A store lasts exactly one cycle, with `mem_we`=1, `mem_addr` equal to the instruction and `mem_wdata` = NOT(A AND B). A store instruction takes 2*ADDR_W+1 cycles, so a full rotation takes 6*ADDR_W+5 cycles.
- R6: The PC wraps from 2^ADDR_W-1 to 0, and fetching continues at address 0.
- R7: A store of 0 to `STOP_ADDR` makes `halted` 1 in the next cycle. `halted` then stays 1 until reset. A store of 1 to `STOP_ADDR`, or a store to any other address, leaves `halted` at 0.
- R8: `halt_req` is sampled only at an instruction boundary, before the first bit is fetched. When it is sampled high, `halted` goes to 1 in the next cycle. An instruction already in progress completes first.
- R9: While `halted` is 1, `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request to stop at the next instruction boundary |
| mem_addr | output | ADDR_W | Bit address to memory: the PC while fetching, the instruction while executing |
| mem_rdata | input | 1 | Bit read from memory, one cycle after its address |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_wdata | output | 1 | NAND of the two loaded operands |
| halted | output | 1 | Machine has stopped |

## Verification
The assertions assume that the memory answers every read exactly one cycle later. They also assume that `halt_req` is a clean synchronous level. The bench memory model returns the bit registered at the previous clock edge. The bench changes `halt_req` only between clock edges, away from the sampling edge.

The assertions do not check any memory contents. Stored results are checked at the ports against a NAND truth table computed in the bench. The program places its operand, result and stop cells outside the code region, so no store can overwrite an instruction.

// File: rtl/serial_nand_pkg.sv
package serial_nand_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_REQ = 3'd0,
        ST_FETCH_CAP = 3'd1,
        ST_LOAD_REQ  = 3'd2,
        ST_LOAD_CAP  = 3'd3,
        ST_STORE     = 3'd4,
        ST_HALTED    = 3'd5
    } sn_state_t;

    typedef enum logic [1:0] {
        PH_LOAD_A = 2'd0,
        PH_LOAD_B = 2'd1,
        PH_STORE  = 2'd2
    } sn_phase_t;

endpackage

// File: rtl/sn_pc_counter.sv
module sn_pc_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [ADDR_W-1:0] pc
);
    // Free-running incrementer: overflow wraps to zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (inc) begin
            pc <= pc + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/sn_ir_fill.sv
module sn_ir_fill #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              clr,
    input  logic              bit_in,
    output logic [ADDR_W-1:0] ir,
    output logic              last_bit,
    output logic              empty
);
    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);

    logic [CNT_W-1:0] fill_cnt;

    // MSB-first assembly: the oldest bit ends up in the top position.
    always_ff @(posedge clk) begin
        if (rst) begin
            ir       <= '0;
            fill_cnt <= '0;
        end else if (shift_en) begin
            ir       <= {ir[ADDR_W-2:0], bit_in};
            fill_cnt <= fill_cnt + CNT_W'(1);
        end else if (clr) begin
            fill_cnt <= '0;
        end
    end

    assign last_bit = (fill_cnt == LAST_IDX);
    assign empty    = (fill_cnt == '0);
endmodule

// File: rtl/sn_nand_alu.sv
module sn_nand_alu (
    input  logic clk,
    input  logic rst,
    input  logic cap_a,
    input  logic cap_b,
    input  logic bit_in,
    output logic result
);
    logic op_a;
    logic op_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= 1'b0;
            op_b <= 1'b0;
        end else begin
            if (cap_a) op_a <= bit_in;
            if (cap_b) op_b <= bit_in;
        end
    end

    assign result = ~(op_a & op_b);
endmodule

// File: rtl/sn_ctl.sv
module sn_ctl
    import serial_nand_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STOP_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              ir_last,
    input  logic              ir_empty,
    input  logic [ADDR_W-1:0] ir,
    input  logic              nand_bit,
    output logic              pc_inc,
    output logic              shift_en,
    output logic              ir_clr,
    output logic              cap_a,
    output logic              cap_b,
    output logic              sel_ir,
    output logic              mem_we,
    output logic              halted
);
    sn_state_t state, state_n;
    sn_phase_t phase, phase_n;
    logic      stop_hit;

    // Stop-address decoder: a zero written to the stop cell.
    assign stop_hit = (ir == STOP_ADDR) && !nand_bit;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_REQ;
            phase <= PH_LOAD_A;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        phase_n = phase;
        unique case (state)
            ST_FETCH_REQ: begin
                if (halt_req && ir_empty) state_n = ST_HALTED;
                else                      state_n = ST_FETCH_CAP;
            end
            ST_FETCH_CAP: begin
                if (!ir_last)               state_n = ST_FETCH_REQ;
                else if (phase == PH_STORE) state_n = ST_STORE;
                else                        state_n = ST_LOAD_REQ;
            end
            ST_LOAD_REQ: state_n = ST_LOAD_CAP;
            ST_LOAD_CAP: begin
                state_n = ST_FETCH_REQ;
                phase_n = (phase == PH_LOAD_A) ? PH_LOAD_B : PH_STORE;
            end
            ST_STORE: begin
                state_n = stop_hit ? ST_HALTED : ST_FETCH_REQ;
                phase_n = PH_LOAD_A;
            end
            ST_HALTED: state_n = ST_HALTED;
            default:   state_n = ST_FETCH_REQ;
        endcase
    end

    // Output decode
    always_comb begin
        pc_inc   = 1'b0;
        shift_en = 1'b0;
        ir_clr   = 1'b0;
        cap_a    = 1'b0;
        cap_b    = 1'b0;
        sel_ir   = 1'b0;
        mem_we   = 1'b0;
        halted   = 1'b0;
        unique case (state)
            ST_FETCH_REQ: ;
            ST_FETCH_CAP: begin
                shift_en = 1'b1;
                pc_inc   = 1'b1;
            end
            ST_LOAD_REQ: sel_ir = 1'b1;
            ST_LOAD_CAP: begin
                sel_ir = 1'b1;
                ir_clr = 1'b1;
                cap_a  = (phase == PH_LOAD_A);
                cap_b  = (phase == PH_LOAD_B);
            end
            ST_STORE: begin
                sel_ir = 1'b1;
                ir_clr = 1'b1;
                mem_we = 1'b1;
            end
            ST_HALTED: halted = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_nand_cpu.sv
module serial_nand_cpu #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STOP_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rdata,
    output logic              mem_we,
    output logic              mem_wdata,
    output logic              halted
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ir_q;
    logic pc_inc, shift_en, ir_clr, cap_a, cap_b, sel_ir;
    logic ir_last, ir_empty, nand_bit;

    sn_pc_counter #(.ADDR_W(ADDR_W)) u_pc (
        .clk(clk), .rst(rst), .inc(pc_inc), .pc(pc_q)
    );

    sn_ir_fill #(.ADDR_W(ADDR_W)) u_ir (
        .clk(clk), .rst(rst), .shift_en(shift_en), .clr(ir_clr),
        .bit_in(mem_rdata), .ir(ir_q), .last_bit(ir_last), .empty(ir_empty)
    );

    sn_nand_alu u_alu (
        .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
        .bit_in(mem_rdata), .result(nand_bit)
    );

    sn_ctl #(.ADDR_W(ADDR_W), .STOP_ADDR(STOP_ADDR)) u_ctl (
        .clk(clk), .rst(rst), .halt_req(halt_req),
        .ir_last(ir_last), .ir_empty(ir_empty), .ir(ir_q), .nand_bit(nand_bit),
        .pc_inc(pc_inc), .shift_en(shift_en), .ir_clr(ir_clr),
        .cap_a(cap_a), .cap_b(cap_b), .sel_ir(sel_ir),
        .mem_we(mem_we), .halted(halted)
    );

    // Address multiplexer: fetch uses the PC, execute uses the instruction.
    assign mem_addr  = sel_ir ? ir_q : pc_q;
    assign mem_wdata = nand_bit;
endmodule

// File: rtl/serial_nand_cpu_chk.sv
module serial_nand_cpu_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STOP_ADDR = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              halt_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_wdata,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic              pc_inc
);
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> pc == $past(pc) + ADDR_W'(1)); // R2
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pc_inc |=> $stable(pc)); // R6
    AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == STOP_ADDR && !mem_wdata) |=> halted); // R7
    AST_OTHER_STORE_RUNS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !(mem_addr == STOP_ADDR && !mem_wdata)) |=> !halted); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R7
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> ($past(halt_req) ||
            $past(mem_we && mem_addr == STOP_ADDR && !mem_wdata))); // R8
    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R9
endmodule

bind serial_nand_cpu serial_nand_cpu_chk #(.ADDR_W(ADDR_W), .STOP_ADDR(STOP_ADDR)) u_chk (
    .clk(clk), .rst(rst), .halt_req(halt_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .halted(halted),
    .pc(pc_q), .pc_inc(pc_inc)
);

// File: tb/serial_nand_cpu_tb.sv
`timescale 1ns/1ps
module serial_nand_cpu_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic halt_req = 1'b0;
    logic load_img = 1'b0;

    // Main instance, ADDR_W = 8, stop cell 255
    logic [7:0] mem_addr;
    logic mem_rdata = 1'b0, mem_we, mem_wdata, halted;
    logic mem [256];
    logic img [256];

    serial_nand_cpu #(.ADDR_W(8), .STOP_ADDR(8'd255)) u_dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (load_img) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else begin
            mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    // Small instance for wrap-around, ADDR_W = 4, zero-filled memory
    logic [3:0] s_addr;
    logic s_rdata = 1'b0, s_we, s_wdata, s_halted;
    logic s_mem [16];

    serial_nand_cpu #(.ADDR_W(4), .STOP_ADDR(4'd15)) u_wrap (
        .clk(clk), .rst(rst), .halt_req(1'b0), .mem_addr(s_addr),
        .mem_rdata(s_rdata), .mem_we(s_we), .mem_wdata(s_wdata), .halted(s_halted)
    );

    always @(posedge clk) begin
        if (load_img) begin
            for (int i = 0; i < 16; i++) s_mem[i] <= 1'b0;
        end else begin
            s_rdata <= s_mem[s_addr];
            if (s_we) s_mem[s_addr] <= s_wdata;
        end
    end

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // {operand A, operand B, expected NAND}
    localparam logic [2:0] VEC [4] = '{3'b001, 3'b011, 3'b101, 3'b110};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_word(input int base, input logic [7:0] val);
        for (int i = 0; i < 8; i++) img[base + i] = val[7 - i];
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int wr_cnt;
        int fetch_bad;
        // Build the program image: six load/load/store triples
        for (int i = 0; i < 256; i++) img[i] = 1'b0;
        for (int t = 0; t < 4; t++) begin
            img[200 + 2*t] = VEC[t][2];
            img[201 + 2*t] = VEC[t][1];
            img[224 + t]   = ~VEC[t][0];
            put_word(24*t,      8'(200 + 2*t));
            put_word(24*t + 8,  8'(201 + 2*t));
            put_word(24*t + 16, 8'(224 + t));
        end
        img[250] = 1'b1;
        img[251] = 1'b0;
        put_word(96, 8'd250);  put_word(104, 8'd251); put_word(112, 8'd255); // writes 1 to stop cell
        put_word(120, 8'd250); put_word(128, 8'd250); put_word(136, 8'd255); // writes 0 to stop cell

        @(negedge clk); load_img = 1'b1;
        @(negedge clk); load_img = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(!halted && !mem_we && mem_addr == 8'd0, "R1 reset state", {halted, mem_we, mem_addr}, 0);

        rst = 1'b0;
        wr_cnt = 0;
        fetch_bad = 0;
        for (int k = 0; k < 360; k++) begin
            if (mem_we) wr_cnt++;
            if (k < 16 && mem_addr != 8'(k / 2)) fetch_bad++;
            if (k == 16) begin
                chk(fetch_bad == 0, "R2 fetch address sequence", fetch_bad, 0);
                chk(mem_addr == 8'd200, "R3 first load address MSB-first", mem_addr, 200);
            end
            if (k == 34) chk(mem_addr == 8'd201, "R4 second load address", mem_addr, 201);
            if (k == 52) chk(mem_we && mem_addr == 8'd224 && mem_wdata,
                             "R5 first store cycle", {mem_we, mem_addr, mem_wdata}, {1'b1, 8'd224, 1'b1});
            if (k == 35) chk(s_addr == 4'd15, "R6 fetch at top address", s_addr, 15);
            if (k == 39) chk(s_addr == 4'd0, "R6 fetch wraps to zero", s_addr, 0);
            if (k == 265) chk(!halted, "R7 store of 1 to stop cell does not halt", halted, 0);
            if (k == 317) chk(!halted && mem_we && mem_addr == 8'd255 && !mem_wdata,
                              "R7 stop store", {halted, mem_we, mem_addr, mem_wdata}, {1'b0, 1'b1, 8'd255, 1'b0});
            if (k == 318) chk(halted, "R7 halted after stop store", halted, 1);
            @(negedge clk);
        end
        chk(wr_cnt == 6, "R9 no stores after halt", wr_cnt, 6);
        chk(halted, "R7 halt is sticky", halted, 1);
        for (int t = 0; t < 4; t++)
            chk(mem[224 + t] == VEC[t][0], "R5 NAND result", mem[224 + t], VEC[t][0]);

        // R8: halt request during an instruction takes effect at the boundary
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!halted && !mem_we && mem_addr == 8'd0, "R1 reset leaves halted state", {halted, mem_we, mem_addr}, 0);
        rst = 1'b0;
        wr_cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (k == 5) halt_req = 1'b1;
            if (mem_we) wr_cnt++;
            if (k == 18) chk(!halted, "R8 instruction in progress completes", halted, 0);
            if (k == 19) chk(halted, "R8 halted at boundary", halted, 1);
            @(negedge clk);
        end
        chk(wr_cnt == 0, "R9 no store with halt request", wr_cnt, 0);

        // R8: halt request held through reset stops before the first fetch
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wr_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            if (mem_we) wr_cnt++;
            if (k == 0) chk(!halted, "R8 not halted before first edge", halted, 0);
            if (k == 1) chk(halted, "R8 halt at first boundary", halted, 1);
            @(negedge clk);
        end
        chk(wr_cnt == 0, "R9 no store when halted immediately", wr_cnt, 0);
        halt_req = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule